// File: doc/BRIEF.md
# Motor Protection and Reset Supervisor

This block watches over a brushless motor drive and decides when the power stage may switch. A slow timebase tick, one clock cycle wide and coming from a low-frequency oscillator, paces all of its timers. After power-on it holds the rest of the control logic in reset for a set number of ticks. After that it allows drive only while the start level is asserted, the motor keeps producing speed-feedback (FG) pulses, the reference clock keeps toggling and no external fault is present.

Two faults are told apart. A motor that gives no FG rising edge for a full stall window is treated as mechanically blocked. The block then latches a stall trip that holds drive off until a long enough stop request, or a power-on reset, clears it. A reference clock that goes quiet for a short window puts the block into intermittent operation: drive is switched on for one tick and off for the next. If the clock comes back before the stall trip fires, normal drive resumes. Once the trip has fired, a returning clock does not restart the drive. An external fault line, such as a thermal or supply flag, blocks drive for exactly as long as it is high.

Top module: `motor_guard_top`

## Requirements
- R1: After reset, `logic_rst_o` and `drive_inhibit_o` are 1 until INIT_TICKS timebase ticks have been seen. After that `logic_rst_o` is 0.
- R2: With `run_req_i`=1, FG rising edges spaced closer than STALL_TICKS ticks, reference-clock falling edges spaced closer than CLKLOSS_TICKS ticks and `fault_i`=0, `drive_inhibit_o` is 0 and `clk_lost_o` is 0.
- R3: With `run_req_i`=0 the block is in the stop (low-power) state. `drive_inhibit_o` is 1 from the next clock on and `clk_lost_o` is 0.
- R4: While running, if FG shows no rising edge for STALL_TICKS ticks, a stall trip latches and `drive_inhibit_o` stays 1 even when FG edges return.
- R5: The stall trip clears only after `run_req_i` has been 0 for STOP_CLEAR_CYC consecutive clocks, or by reset. A shorter stop leaves it set.
- R6: While running, if the reference clock shows no falling edge for CLKLOSS_TICKS ticks, `clk_lost_o` is 1. It is 0 while not running.
- R7: While `clk_lost_o` is 1, drive alternates each tick: the first tick period is off (`drive_inhibit_o`=1), the next is on, and so on.
- R8: If reference-clock edges return before a stall trip, `clk_lost_o` falls and `drive_inhibit_o` returns to 0.
- R9: If reference-clock edges return after a stall trip, `clk_lost_o` falls but `drive_inhibit_o` stays 1.
- R10: `fault_i`=1 forces `drive_inhibit_o` to 1 in the same cycle. It does not latch: drive returns as soon as `fault_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_i | input | 1 | One-cycle timebase tick from the slow oscillator |
| fg_i | input | 1 | Speed-feedback pulse, asynchronous |
| ref_clk_i | input | 1 | Reference clock, asynchronous |
| run_req_i | input | 1 | 1 = start, 0 = stop |
| fault_i | input | 1 | External fault (thermal or undervoltage), forces inhibit |
| logic_rst_o | output | 1 | Reset for the downstream control logic |
| drive_inhibit_o | output | 1 | 1 = power stage switching blocked |
| clk_lost_o | output | 1 | Reference clock missing, intermittent operation active |

## Verification
A stall latch stuck at 1 shows as `drive_inhibit_o` staying high after a valid restart. A latch that clears too early shows as drive resuming after a short stop, within a few ticks of `run_req_i` rising. A miscounted stall or clock-loss window moves the rising edge of `drive_inhibit_o` or `clk_lost_o` by whole ticks, so the bench samples a few ticks on either side of the nominal window. A wrong intermittent phase shows within one tick of clock loss as two tick periods with the same inhibit value.

// File: rtl/mg_pkg.sv
package mg_pkg;

    typedef enum logic [1:0] {
        SUP_INIT = 2'd0,
        SUP_STOP = 2'd1,
        SUP_RUN  = 2'd2
    } sup_state_e;

    typedef struct packed {
        logic logic_rst;
        logic inhibit;
        logic clk_lost;
    } sup_out_t;

    // bits needed to hold values 0..lim
    function automatic int cnt_width(input int lim);
        return (lim < 1) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/mg_edge_sync.sv
module mg_edge_sync #(
    parameter int STAGES = 2,
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_o
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], din};
            prev_q <= sh_q[STAGES-1];
        end
    end

    generate
        if (RISING) begin : g_rise
            assign edge_o = sh_q[STAGES-1] & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~sh_q[STAGES-1] & prev_q;
        end
    endgenerate
endmodule

// File: rtl/mg_tick_counter.sv
module mg_tick_counter import mg_pkg::*; #(
    parameter int LIMIT = 31
) (
    input  logic clk,
    input  logic rst,
    input  logic enable_i,
    input  logic clear_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int W = cnt_width(LIMIT);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !enable_i || clear_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == LIM);
endmodule

// File: rtl/mg_supervisor.sv
module mg_supervisor import mg_pkg::*; #(
    parameter int INIT_TICKS     = 1,
    parameter int STOP_CLEAR_CYC = 5000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_i,
    input  logic     run_req_i,
    input  logic     fault_i,
    input  logic     stall_exp_i,
    input  logic     lost_exp_i,
    output logic     run_o,
    output logic     stall_o,
    output sup_out_t out_o
);
    localparam int IW = cnt_width(INIT_TICKS);
    localparam int SW = cnt_width(STOP_CLEAR_CYC);
    localparam logic [IW-1:0] INIT_LAST = IW'(INIT_TICKS - 1);
    localparam logic [SW-1:0] STOP_DONE = SW'(STOP_CLEAR_CYC);

    sup_state_e    state_q;
    logic [IW-1:0] init_cnt_q;
    logic [SW-1:0] stop_cnt_q;
    logic          stall_q;
    logic          phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SUP_INIT;
            init_cnt_q <= '0;
        end else begin
            case (state_q)
                SUP_INIT: begin
                    if (tick_i) begin
                        if (init_cnt_q == INIT_LAST) begin
                            state_q <= run_req_i ? SUP_RUN : SUP_STOP;
                        end else begin
                            init_cnt_q <= init_cnt_q + 1'b1;
                        end
                    end
                end
                SUP_STOP: if (run_req_i)  state_q <= SUP_RUN;
                SUP_RUN:  if (!run_req_i) state_q <= SUP_STOP;
                default:  state_q <= SUP_INIT;
            endcase
        end
    end

    // length of the current uninterrupted stop request
    always_ff @(posedge clk) begin
        if (rst || state_q != SUP_STOP || run_req_i) begin
            stop_cnt_q <= '0;
        end else if (stop_cnt_q != STOP_DONE) begin
            stop_cnt_q <= stop_cnt_q + 1'b1;
        end
    end

    // stall trip: set in run, cleared only by a long stop
    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q <= 1'b0;
        end else if (state_q == SUP_RUN && stall_exp_i) begin
            stall_q <= 1'b1;
        end else if (stop_cnt_q == STOP_DONE && !run_req_i) begin
            stall_q <= 1'b0;
        end
    end

    // intermittent on/off phase, starts in the off half
    always_ff @(posedge clk) begin
        if (rst || !lost_exp_i) begin
            phase_q <= 1'b0;
        end else if (tick_i) begin
            phase_q <= ~phase_q;
        end
    end

    assign run_o           = (state_q == SUP_RUN);
    assign stall_o         = stall_q;
    assign out_o.logic_rst = (state_q == SUP_INIT);
    assign out_o.clk_lost  = lost_exp_i;
    assign out_o.inhibit   = (state_q != SUP_RUN) | stall_q | fault_i
                           | (lost_exp_i & ~phase_q);
endmodule

// File: rtl/motor_guard_top.sv
module motor_guard_top import mg_pkg::*; #(
    parameter int INIT_TICKS     = 1,
    parameter int STALL_TICKS    = 31,
    parameter int CLKLOSS_TICKS  = 2,
    parameter int STOP_CLEAR_CYC = 5000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic fg_i,
    input  logic ref_clk_i,
    input  logic run_req_i,
    input  logic fault_i,
    output logic logic_rst_o,
    output logic drive_inhibit_o,
    output logic clk_lost_o
);
    logic     fg_edge, ref_edge;
    logic     run, stall_q;
    logic     stall_exp, lost_exp;
    sup_out_t sup_out;

    mg_edge_sync #(.STAGES(SYNC_STAGES), .RISING(1'b1)) u_fg_sync (
        .clk(clk), .rst(rst), .din(fg_i), .edge_o(fg_edge)
    );

    mg_edge_sync #(.STAGES(SYNC_STAGES), .RISING(1'b0)) u_ref_sync (
        .clk(clk), .rst(rst), .din(ref_clk_i), .edge_o(ref_edge)
    );

    mg_tick_counter #(.LIMIT(STALL_TICKS)) u_stall_cnt (
        .clk(clk), .rst(rst), .enable_i(run & ~stall_q),
        .clear_i(fg_edge), .tick_i(tick_i), .expired_o(stall_exp)
    );

    mg_tick_counter #(.LIMIT(CLKLOSS_TICKS)) u_lost_cnt (
        .clk(clk), .rst(rst), .enable_i(run),
        .clear_i(ref_edge), .tick_i(tick_i), .expired_o(lost_exp)
    );

    mg_supervisor #(.INIT_TICKS(INIT_TICKS), .STOP_CLEAR_CYC(STOP_CLEAR_CYC)) u_sup (
        .clk(clk), .rst(rst), .tick_i(tick_i), .run_req_i(run_req_i),
        .fault_i(fault_i), .stall_exp_i(stall_exp), .lost_exp_i(lost_exp),
        .run_o(run), .stall_o(stall_q), .out_o(sup_out)
    );

    assign logic_rst_o     = sup_out.logic_rst;
    assign drive_inhibit_o = sup_out.inhibit;
    assign clk_lost_o      = sup_out.clk_lost;
endmodule

// File: rtl/mg_checks.sv
module mg_checks (
    input logic clk,
    input logic rst,
    input logic run_req_i,
    input logic fault_i,
    input logic logic_rst_o,
    input logic drive_inhibit_o,
    input logic clk_lost_o,
    input logic stall_q
);
    assert_reset_blocks_R1: assert property (@(posedge clk) disable iff (rst)
        logic_rst_o |-> drive_inhibit_o);

    assert_stop_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        !run_req_i |=> drive_inhibit_o);

    assert_stall_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        stall_q |-> drive_inhibit_o);

    assert_stall_sets_in_run_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(stall_q) |-> $past(run_req_i));

    assert_stall_held_in_run_R5: assert property (@(posedge clk) disable iff (rst)
        (stall_q && run_req_i) |=> stall_q);

    assert_lost_not_in_reset_R6: assert property (@(posedge clk) disable iff (rst)
        clk_lost_o |-> !logic_rst_o);

    assert_burst_starts_off_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_lost_o) |-> drive_inhibit_o);

    assert_fault_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        fault_i |-> drive_inhibit_o);
endmodule

bind motor_guard_top mg_checks u_mg_checks (
    .clk(clk), .rst(rst), .run_req_i(run_req_i), .fault_i(fault_i),
    .logic_rst_o(logic_rst_o), .drive_inhibit_o(drive_inhibit_o),
    .clk_lost_o(clk_lost_o), .stall_q(stall_q)
);

// File: tb/motor_guard_top_tb_top.sv
`timescale 1ns/1ps
module motor_guard_top_tb_top;
    localparam int TP = 10;  // clocks per timebase tick

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, fg = 1'b0, refc = 1'b0, run_req = 1'b0, fault = 1'b0;
    logic lrst, inh, lost;

    logic fg_en = 1'b0, ref_en = 1'b0;
    int   fg_half = 25;
    int   n_vec = 0, n_bad = 0;
    bit   done = 1'b0;

    typedef struct {
        string      tag;
        logic [2:0] mask;  // {logic_rst, inhibit, clk_lost}
        logic [2:0] exp;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    motor_guard_top dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .fg_i(fg), .ref_clk_i(refc),
        .run_req_i(run_req), .fault_i(fault), .logic_rst_o(lrst),
        .drive_inhibit_o(inh), .clk_lost_o(lost)
    );

    // timebase
    initial forever begin
        repeat (TP - 1) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    end

    // FG generator
    initial forever begin
        @(negedge clk);
        if (fg_en) begin
            repeat (fg_half - 1) @(negedge clk);
            fg = ~fg;
        end
    end

    // reference clock generator
    initial forever begin
        repeat (4) @(negedge clk);
        if (ref_en) refc = ~refc;
    end

    // monitor: compares each queued item shortly after the falling edge
    initial forever begin
        @(negedge clk);
        #2;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [2:0] act;
            it  = sb_q.pop_front();
            act = {lrst, inh, lost};
            n_vec++;
            if ((act & it.mask) !== (it.exp & it.mask)) begin
                n_bad++;
                $display("FAIL %s: actual {rst,inh,lost}=%b expected %b (mask %b)",
                         it.tag, act, it.exp, it.mask);
            end
        end
    end

    task automatic expect_out(input string tag, input logic [2:0] mask, input logic [2:0] exp);
        item_t it;
        it.tag = tag; it.mask = mask; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!tick);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic v1;
        run_req = 1'b1; fg_en = 1'b1; ref_en = 1'b1;
        wait_cyc(5);
        rst = 1'b0;
        expect_out("R1 reset held before first tick", 3'b110, 3'b110);
        wait_cyc(2);
        wait_ticks(2);
        expect_out("R1 reset released after tick", 3'b100, 3'b000);

        // R2 normal run
        wait_ticks(3);
        expect_out("R2 running fast FG", 3'b111, 3'b000);
        fg_half = 60;
        wait_ticks(40);
        expect_out("R2 running slow FG", 3'b111, 3'b000);
        fg_half = 25;
        wait_ticks(3);

        // R10 fault, non latching
        fault = 1'b1;
        expect_out("R10 fault forces inhibit", 3'b010, 3'b010);
        wait_cyc(7);
        expect_out("R10 fault still held", 3'b010, 3'b010);
        wait_cyc(1);
        fault = 1'b0;
        expect_out("R10 fault released", 3'b010, 3'b000);

        // R6 / R7 clock loss and intermittent mode
        ref_en = 1'b0;
        wait_ticks(4);
        expect_out("R6 clock loss flagged", 3'b001, 3'b001);
        wait_ticks(1);
        wait_cyc(2);
        v1 = inh;
        wait_ticks(1);
        wait_cyc(2);
        expect_out("R7 intermittent alternates", 3'b011, {1'b0, ~v1, 1'b1});
        v1 = ~v1;
        wait_ticks(1);
        wait_cyc(2);
        expect_out("R7 intermittent alternates again", 3'b011, {1'b0, ~v1, 1'b1});

        // R8 clock returns before trip
        ref_en = 1'b1;
        wait_ticks(2);
        expect_out("R8 clock back, drive resumes", 3'b011, 3'b000);

        // R4 stall
        fg_en = 1'b0;
        wait_ticks(20);
        expect_out("R4 no trip before window", 3'b010, 3'b000);
        wait_ticks(14);
        expect_out("R4 stall trip", 3'b010, 3'b010);
        fg_en = 1'b1;
        wait_ticks(10);
        expect_out("R4 trip latched with FG back", 3'b010, 3'b010);

        // R5 short stop does not clear, long stop does
        run_req = 1'b0;
        wait_cyc(2000);
        run_req = 1'b1;
        wait_ticks(5);
        expect_out("R5 short stop keeps trip", 3'b010, 3'b010);
        run_req = 1'b0;
        wait_cyc(3);
        // R3 stop state
        expect_out("R3 stop inhibits, no clock flag", 3'b011, 3'b010);
        wait_cyc(5200);
        run_req = 1'b1;
        wait_ticks(3);
        expect_out("R5 long stop clears trip", 3'b011, 3'b000);

        // R9 clock returns after trip
        ref_en = 1'b0; fg_en = 1'b0;
        wait_ticks(36);
        expect_out("R9 trip with clock lost", 3'b011, 3'b011);
        ref_en = 1'b1; fg_en = 1'b1;
        wait_ticks(4);
        expect_out("R9 clock back, drive stays off", 3'b011, 3'b010);

        wait_cyc(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule